// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block decides which hardware thread of a simultaneous-multithreading out-of-order core may retire an instruction in a commit slot. Every thread presents its commit status, a flag that says its reorder buffer is empty, a flag that says its oldest buffered instruction is ready to retire, and that instruction's sequence number. From these the block produces, without a clock edge in between, a grant-valid flag and the index of the chosen thread.

Three policies are chosen at run time. The aggressive and oldest-ready policies pick the ready thread whose head instruction is oldest. The round-robin policy scans a priority list and rotates only the thread that was granted to the back. The commit stage may ask several times in one cycle, once for each slot, by changing the inputs. It raises the consume strobe when it takes a grant, and the round-robin list then moves on the next clock edge. A build with a single thread skips arbitration entirely.

Top module: `commit_thread_select`

## Requirements
- R1: Status codes are 3 bits per thread at bits [3i+2:3i]: 0 idle, 1 running, 2 squashing, 3 trap waiting, 4 fetch-trap waiting. Only codes 0, 1 and 4 make a thread eligible. A thread with any other code is never granted.
- R2: Policy codes are 0 aggressive, 1 round-robin, 2 oldest-ready and 3, which behaves as oldest-ready. The aggressive policy gives the same grant as oldest-ready for the same inputs.
- R3: Under oldest-ready, a candidate is a thread that is eligible, has a non-empty buffer and has a ready head. The grant goes to the candidate with the smallest head sequence number, compared as unsigned. Thread i's sequence number sits at bits [SEQ_W*i+SEQ_W-1:SEQ_W*i].
- R4: When candidates have equal sequence numbers, the lowest thread index wins.
- R5: Under round-robin, the priority list is scanned from its front. The first entry naming a candidate (eligible, non-empty, ready head) is granted.
- R6: The list changes on a rising clock edge only when grantTake is high, grantValid is high and the policy is round-robin. The granted entry then moves to the tail and the other entries keep their order. In every other case the list is held.
- R7: Reset, active low, loads the list with 0 at the front through NUM_THREADS-1 at the tail.
- R8: When no thread qualifies, grantValid is 0 and grantThread is 0.
- R9: With NUM_THREADS = 1, thread 0 is granted exactly when its status is eligible, whatever the policy, empty flag or ready flag.
- R10: The grant follows the per-thread inputs combinationally, in the same cycle they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Selection policy code |
| threadStatus | input | 3*NUM_THREADS | Per-thread commit status codes |
| robEmpty | input | NUM_THREADS | Per-thread reorder buffer empty |
| headReady | input | NUM_THREADS | Per-thread head instruction ready |
| headSeq | input | SEQ_W*NUM_THREADS | Per-thread head sequence numbers |
| grantTake | input | 1 | The commit stage consumed the current grant |
| grantValid | output | 1 | A thread was selected |
| grantThread | output | IDX_W | Index of the selected thread |

## Verification
Oldest-ready is exercised with a distinct minimum, a minimum on a thread that is not ready, a tie, and a minimum on an ineligible or empty thread. Each of these separates a true age comparison from a fixed-priority pick. Round-robin is driven through a chain of consumed grants with changing ready masks, so that rotating only the winner can be told apart from a plain pointer advance. Consumes under oldest-ready and cycles without a consume show whether the list is held. A second, single-thread instance shows that readiness is ignored when only one thread exists.

// File: rtl/commit_sel_pkg.sv
package commit_sel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUNNING    = 3'd1,
    ST_SQUASHING  = 3'd2,
    ST_TRAP_WAIT  = 3'd3,
    ST_FETCH_TRAP = 3'd4
  } thrStatus_e;

  typedef enum logic [1:0] {
    POL_AGGRESSIVE  = 2'd0,
    POL_ROUND_ROBIN = 2'd1,
    POL_OLDEST      = 2'd2,
    POL_OLDEST_ALT  = 2'd3
  } selPolicy_e;

  // Strobes from control to the priority-list datapath
  typedef struct packed {
    logic       rotate;
    logic [2:0] rotPos;
  } listStrobe_t;

  function automatic logic isEligible(input logic [2:0] st);
    return (st == ST_IDLE) || (st == ST_RUNNING) || (st == ST_FETCH_TRAP);
  endfunction

endpackage

// File: rtl/csel_datapath.sv
module csel_datapath
  import commit_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int IDX_W       = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  listStrobe_t                  strobe,
  input  logic [NUM_THREADS-1:0]       candMask,
  input  logic [NUM_THREADS*SEQ_W-1:0] headSeq,
  output logic [NUM_THREADS*IDX_W-1:0] prioList,
  output logic                         oldestValid,
  output logic [IDX_W-1:0]             oldestIdx
);

  logic [IDX_W-1:0] listQ   [NUM_THREADS];
  logic [IDX_W-1:0] listNxt [NUM_THREADS];
  logic [SEQ_W-1:0] bestSeq;

  // Remove the entry at rotPos and append it at the tail
  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) listNxt[i] = listQ[i];
    if (strobe.rotate) begin
      for (int i = 0; i < NUM_THREADS - 1; i++)
        if (i >= int'(strobe.rotPos)) listNxt[i] = listQ[i+1];
      listNxt[NUM_THREADS-1] = listQ[strobe.rotPos[IDX_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_THREADS; i++) listQ[i] <= IDX_W'(i);
    end else begin
      for (int i = 0; i < NUM_THREADS; i++) listQ[i] <= listNxt[i];
    end
  end

  for (genvar g = 0; g < NUM_THREADS; g++) begin : gFlat
    assign prioList[g*IDX_W +: IDX_W] = listQ[g];
  end

  // Oldest candidate; strict compare keeps the lower index on ties
  always_comb begin
    oldestValid = 1'b0;
    oldestIdx   = '0;
    bestSeq     = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (candMask[i] && (!oldestValid || headSeq[i*SEQ_W +: SEQ_W] < bestSeq)) begin
        oldestValid = 1'b1;
        oldestIdx   = IDX_W'(i);
        bestSeq     = headSeq[i*SEQ_W +: SEQ_W];
      end
    end
  end

endmodule

// File: rtl/csel_control.sv
module csel_control
  import commit_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int IDX_W       = 2
) (
  input  logic [1:0]                   policy,
  input  logic [3*NUM_THREADS-1:0]     threadStatus,
  input  logic [NUM_THREADS-1:0]       robEmpty,
  input  logic [NUM_THREADS-1:0]       headReady,
  input  logic [NUM_THREADS*IDX_W-1:0] prioList,
  input  logic                         oldestValid,
  input  logic [IDX_W-1:0]             oldestIdx,
  input  logic                         grantTake,
  output logic [NUM_THREADS-1:0]       candMask,
  output listStrobe_t                  strobe,
  output logic                         grantValid,
  output logic [IDX_W-1:0]             grantThread
);

  logic [NUM_THREADS-1:0] eligible;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : gElig
    assign eligible[g] = isEligible(threadStatus[3*g +: 3]);
  end

  assign candMask = eligible & headReady & ~robEmpty;

  if (NUM_THREADS == 1) begin : gSingle
    assign grantValid  = eligible[0];
    assign grantThread = '0;
    assign strobe      = '0;
  end else begin : gMulti
    logic             rrFound;
    logic [IDX_W-1:0] rrIdx;
    logic [IDX_W-1:0] entry;
    int               rrPos;
    selPolicy_e       pol;

    assign pol = selPolicy_e'(policy);

    always_comb begin
      rrFound = 1'b0;
      rrIdx   = '0;
      rrPos   = 0;
      entry   = '0;
      for (int k = 0; k < NUM_THREADS; k++) begin
        entry = prioList[k*IDX_W +: IDX_W];
        if (!rrFound && candMask[entry]) begin
          rrFound = 1'b1;
          rrIdx   = entry;
          rrPos   = k;
        end
      end
    end

    always_comb begin
      if (pol == POL_ROUND_ROBIN) begin
        grantValid  = rrFound;
        grantThread = rrIdx;
      end else begin
        grantValid  = oldestValid;
        grantThread = oldestIdx;
      end
      strobe.rotate = grantTake && rrFound && (pol == POL_ROUND_ROBIN);
      strobe.rotPos = 3'(rrPos);
    end
  end

endmodule

// File: rtl/commit_thread_select.sv
module commit_thread_select
  import commit_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int IDX_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   policy,
  input  logic [3*NUM_THREADS-1:0]     threadStatus,
  input  logic [NUM_THREADS-1:0]       robEmpty,
  input  logic [NUM_THREADS-1:0]       headReady,
  input  logic [NUM_THREADS*SEQ_W-1:0] headSeq,
  input  logic                         grantTake,
  output logic                         grantValid,
  output logic [IDX_W-1:0]             grantThread
);

  listStrobe_t                  strobe;
  logic [NUM_THREADS-1:0]       candMask;
  logic [NUM_THREADS*IDX_W-1:0] prioList;
  logic                         oldestValid;
  logic [IDX_W-1:0]             oldestIdx;

  csel_datapath #(
    .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .IDX_W(IDX_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .candMask(candMask),
    .headSeq(headSeq), .prioList(prioList),
    .oldestValid(oldestValid), .oldestIdx(oldestIdx)
  );

  csel_control #(
    .NUM_THREADS(NUM_THREADS), .IDX_W(IDX_W)
  ) uCtl (
    .policy(policy), .threadStatus(threadStatus), .robEmpty(robEmpty),
    .headReady(headReady), .prioList(prioList), .oldestValid(oldestValid),
    .oldestIdx(oldestIdx), .grantTake(grantTake), .candMask(candMask),
    .strobe(strobe), .grantValid(grantValid), .grantThread(grantThread)
  );

endmodule

// File: rtl/commit_thread_select_chk.sv
module commit_thread_select_chk #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int IDX_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [1:0]                   policy,
  input logic [3*NUM_THREADS-1:0]     threadStatus,
  input logic [NUM_THREADS-1:0]       robEmpty,
  input logic [NUM_THREADS-1:0]       headReady,
  input logic                         grantTake,
  input logic                         grantValid,
  input logic [IDX_W-1:0]             grantThread,
  input logic [NUM_THREADS*IDX_W-1:0] prioList
);

  logic [2:0] grantStatus;
  logic       anyReady;
  logic       rotating;
  logic       multi;

  assign grantStatus = threadStatus[3*grantThread +: 3];
  assign anyReady    = |(headReady & ~robEmpty);
  assign rotating    = grantTake && grantValid && (policy == 2'd1);
  assign multi       = (NUM_THREADS > 1);

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantStatus == 3'd0 || grantStatus == 3'd1 || grantStatus == 3'd4)); // R1

  AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (multi && grantValid) |-> (headReady[grantThread] && !robEmpty[grantThread])); // R5

  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (multi && !anyReady) |-> !grantValid); // R8

  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> (grantThread == '0)); // R8

  AST_LIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rotating |=> $stable(prioList)); // R6

  AST_LIST_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    (multi && rotating) |=> (prioList[(NUM_THREADS-1)*IDX_W +: IDX_W] == $past(grantThread))); // R6

endmodule

bind commit_thread_select commit_thread_select_chk #(
  .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W)
) uChk (.*);

// File: tb/sim_commit_thread_select.sv
module sim_commit_thread_select;

  localparam logic [11:0] ALLR = {3'd1, 3'd1, 3'd1, 3'd1};

  typedef struct packed {
    logic [1:0]  pol;
    logic [11:0] st;
    logic [3:0]  emp;
    logic [3:0]  rdy;
    logic [31:0] seq;
    logic        expV;
    logic [1:0]  expT;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd2, ALLR, 4'h0, 4'hF, {8'd40, 8'd30, 8'd20, 8'd10}, 1'b1, 2'd0},
    '{2'd2, ALLR, 4'h0, 4'hF, {8'd5, 8'd30, 8'd20, 8'd10},  1'b1, 2'd3},
    '{2'd2, ALLR, 4'h0, 4'h6, {8'd5, 8'd30, 8'd20, 8'd10},  1'b1, 2'd1},
    '{2'd2, ALLR, 4'h0, 4'hE, {8'd7, 8'd7, 8'd7, 8'd9},     1'b1, 2'd1},
    '{2'd2, {3'd1, 3'd3, 3'd2, 3'd1}, 4'h0, 4'hF, {8'd50, 8'd1, 8'd2, 8'd60}, 1'b1, 2'd3},
    '{2'd2, {3'd4, 3'd2, 3'd2, 3'd0}, 4'h0, 4'hF, {8'd3, 8'd0, 8'd0, 8'd4},   1'b1, 2'd3},
    '{2'd2, ALLR, 4'h1, 4'hF, {8'd40, 8'd30, 8'd20, 8'd1},  1'b1, 2'd1},
    '{2'd0, ALLR, 4'h0, 4'h6, {8'd5, 8'd30, 8'd20, 8'd10},  1'b1, 2'd1},
    '{2'd2, ALLR, 4'h0, 4'h0, {8'd1, 8'd2, 8'd3, 8'd4},     1'b0, 2'd0},
    '{2'd2, {3'd2, 3'd3, 3'd2, 3'd3}, 4'h0, 4'hF, {8'd1, 8'd2, 8'd3, 8'd4}, 1'b0, 2'd0},
    '{2'd3, ALLR, 4'h0, 4'hF, {8'd5, 8'd30, 8'd20, 8'd10},  1'b1, 2'd3}
  };
  localparam string TAGS [NV] = '{"R3", "R3", "R3", "R4", "R1", "R1",
                                  "R3", "R2", "R8", "R8", "R2"};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pol = '0;
  logic [11:0] st = '0;
  logic [3:0]  emp = '0;
  logic [3:0]  rdy = '0;
  logic [31:0] seq = '0;
  logic        take = 1'b0;
  logic        gV;
  logic [1:0]  gT;

  logic [1:0]  sPol = '0;
  logic [2:0]  sSt = '0;
  logic        sEmp = 1'b0;
  logic        sRdy = 1'b0;
  logic [7:0]  sSeq = '0;
  logic        sV;
  logic [0:0]  sT;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  commit_thread_select #(.NUM_THREADS(4), .SEQ_W(8)) u0 (
    .clk(clk), .rstN(rstN), .policy(pol), .threadStatus(st), .robEmpty(emp),
    .headReady(rdy), .headSeq(seq), .grantTake(take),
    .grantValid(gV), .grantThread(gT)
  );

  commit_thread_select #(.NUM_THREADS(1), .SEQ_W(8)) u1 (
    .clk(clk), .rstN(rstN), .policy(sPol), .threadStatus(sSt), .robEmpty(sEmp),
    .headReady(sRdy), .headSeq(sSeq), .grantTake(1'b0),
    .grantValid(sV), .grantThread(sT)
  );

  task automatic check(input string tag, input logic v, input logic [1:0] t,
                       input logic ev, input logic [1:0] et);
    nChecks++;
    if (v !== ev || t !== et) begin
      nFails++;
      $display("FAIL %s: valid/thread got %0d/%0d expected %0d/%0d", tag, v, t, ev, et);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic [11:0] s, input logic [3:0] e,
                       input logic [3:0] r, input logic [31:0] q, input logic tk);
    @(negedge clk);
    pol = p; st = s; emp = e; rdy = r; seq = q; take = tk;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    take = 1'b0;
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    // R7: list starts 0,1,2,3
    drive(2'd1, ALLR, 4'h0, 4'hF, '0, 1'b0); check("R7", gV, gT, 1'b1, 2'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].pol, VECS[i].st, VECS[i].emp, VECS[i].rdy, VECS[i].seq, 1'b0);
      check(TAGS[i], gV, gT, VECS[i].expV, VECS[i].expT);
    end

    // Round-robin chain; list 0123
    drive(2'd1, ALLR, 4'h0, 4'hF, '0, 1'b1); check("R5", gV, gT, 1'b1, 2'd0); // -> 1230
    drive(2'd1, ALLR, 4'h0, 4'hF, '0, 1'b1); check("R6", gV, gT, 1'b1, 2'd1); // -> 2301
    drive(2'd1, ALLR, 4'h0, 4'h9, '0, 1'b1); check("R5", gV, gT, 1'b1, 2'd3); // -> 2013
    drive(2'd1, ALLR, 4'h0, 4'hF, '0, 1'b0); check("R5", gV, gT, 1'b1, 2'd2);
    drive(2'd1, ALLR, 4'h0, 4'hF, '0, 1'b0); check("R6", gV, gT, 1'b1, 2'd2);
    drive(2'd1, {3'd1, 3'd3, 3'd1, 3'd1}, 4'h0, 4'hF, '0, 1'b1);
    check("R1", gV, gT, 1'b1, 2'd0);                                       // -> 2130
    drive(2'd1, ALLR, 4'h0, 4'hF, '0, 1'b1); check("R6", gV, gT, 1'b1, 2'd2); // -> 1302
    drive(2'd2, ALLR, 4'h0, 4'hF, {8'd4, 8'd3, 8'd2, 8'd1}, 1'b1);
    check("R3", gV, gT, 1'b1, 2'd0);                                       // list held
    drive(2'd1, ALLR, 4'h0, 4'hF, '0, 1'b0); check("R6", gV, gT, 1'b1, 2'd1);
    drive(2'd1, ALLR, 4'h0, 4'h0, '0, 1'b0); check("R8", gV, gT, 1'b0, 2'd0);
    drive(2'd1, ALLR, 4'hF, 4'hF, '0, 1'b0); check("R8", gV, gT, 1'b0, 2'd0);
    drive(2'd1, ALLR, 4'h0, 4'h5, '0, 1'b0); check("R5", gV, gT, 1'b1, 2'd0);

    doReset();
    drive(2'd1, ALLR, 4'h0, 4'hF, '0, 1'b0); check("R7", gV, gT, 1'b1, 2'd0);
    drive(2'd1, ALLR, 4'h0, 4'h4, '0, 1'b0); check("R10", gV, gT, 1'b1, 2'd2);

    // Single-thread instance
    @(negedge clk); sPol = 2'd1; sSt = 3'd1; sEmp = 1'b1; sRdy = 1'b0; #1;
    check("R9", sV, {1'b0, sT}, 1'b1, 2'd0);
    @(negedge clk); sSt = 3'd2; #1;
    check("R9", sV, {1'b0, sT}, 1'b0, 2'd0);
    @(negedge clk); sPol = 2'd2; sSt = 3'd4; #1;
    check("R9", sV, {1'b0, sT}, 1'b1, 2'd0);
    @(negedge clk); sSt = 3'd3; #1;
    check("R9", sV, {1'b0, sT}, 1'b0, 2'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule